// File: doc/BRIEF.md
# Segment Map Register File with Mirrored Instruction Copy

This block keeps the sixteen segment entries that divide a 32-bit effective address space into equal 256 MB regions. The four most significant address bits choose the entry. Two physical copies are kept. The primary copy serves data-side lookups and the register move-out port. The mirror copy serves instruction-side lookups, so that fetch translation never competes with data translation for a read port.

Register moves are privileged. A move-in with the supervisor input high writes the same value into both copies on the clock edge. A move-out with the supervisor input high returns the primary copy. If either move is attempted with the supervisor input low, nothing changes, the move-out result is zero, and a fault pulse lasting one cycle is raised. All outputs are registered, so every result appears one cycle after its request. A lookup issued in the same cycle as a write to the same entry returns the value held before that write.

Top module: `segmap_top`

## Requirements
- R1: Each lookup port returns, one cycle after the address is presented, the 32-bit entry whose index equals effective address bits [31:28]; address bits [27:0] have no effect.
- R2: A move-in (`mv_wr_en`=1 with `sup_mode`=1) stores `mv_wr_data` at `mv_wr_idx` in both copies on that clock edge, and lookups presented in the following cycle on either port return the new value.
- R3: The data and instruction lookup ports, given addresses with the same index in the same cycle, return equal values in the next cycle.
- R4: A move-out (`mv_rd_en`=1 with `sup_mode`=1) puts the primary entry at `mv_rd_idx` on `mv_rd_data` in the following cycle.
- R5: A lookup or move-out that targets the entry being written in the same cycle returns the value held before that write.
- R6: A move-in or move-out request with `sup_mode`=0 drives `priv_fault` high for exactly the next cycle; `priv_fault` stays low in the cycle after any cycle with `sup_mode`=1.
- R7: A refused move-in changes neither copy, and a refused move-out gives `mv_rd_data` = 0 in the next cycle.
- R8: With `rst_n` low at a clock edge, both copies and all outputs become zero.
- R9: `mv_rd_data` is zero in the cycle after any cycle with no move-out request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sup_mode | input | 1 | 1 = supervisor level, 0 = user level |
| mv_wr_en | input | 1 | Move-in request |
| mv_wr_idx | input | 4 | Entry index for move-in |
| mv_wr_data | input | 32 | Value to store |
| mv_rd_en | input | 1 | Move-out request |
| mv_rd_idx | input | 4 | Entry index for move-out |
| mv_rd_data | output | 32 | Move-out result, registered |
| priv_fault | output | 1 | One-cycle pulse after a refused move |
| d_ea | input | 32 | Data-side effective address |
| d_entry | output | 32 | Data-side selected entry, registered |
| i_ea | input | 32 | Instruction-side effective address |
| i_entry | output | 32 | Instruction-side selected entry, registered |

## Verification
The assertions check on every cycle that both copies agree whenever the two lookup ports hit the same index, that a user-level move raises the fault in the next cycle, that supervisor cycles never fault, and that a refused or absent move-out yields zero. What only the bench scenarios can show is what each entry holds over time: that a refused write leaves the old contents, that a same-cycle write and lookup return the older value, that every one of the sixteen entries is reachable through the top address bits, and that reset clears both copies. The bench checks these against a reference model across directed and random sequences.

// File: rtl/segmap_pkg.sv
// Package: segmap_pkg
// Shared sizes and index type for the segment map register file.
// Assumes the entry count is a power of two.
package segmap_pkg;
    localparam int SEG_ENTRIES = 16;
    localparam int SEG_WIDTH   = 32;
    localparam int EA_WIDTH    = 32;
    localparam int SEG_IDX_W   = $clog2(SEG_ENTRIES);

    typedef logic [SEG_IDX_W-1:0] seg_idx_t;
    typedef logic [SEG_WIDTH-1:0] seg_word_t;
endpackage

// File: rtl/segmap_guard.sv
// Module: segmap_guard
// Decides whether register moves may proceed at the current privilege level
// and raises a registered fault pulse when a move is refused.
// Assumes requests are single-cycle and sampled on the rising edge.
module segmap_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_mode,
    input  logic wr_req,
    input  logic rd_req,
    output logic wr_ok,
    output logic rd_ok,
    output logic fault_q
);
    logic refused;

    // Gate moves by privilege level.
    always_comb begin
        wr_ok   = wr_req & sup_mode;
        rd_ok   = rd_req & sup_mode;
        refused = (wr_req | rd_req) & ~sup_mode;
    end

    // Register the fault so it lasts one cycle per refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= refused;
    end
endmodule

// File: rtl/segmap_bank.sv
// Module: segmap_bank
// One copy of the segment entries: a single write port and PORTS registered
// read ports. A read whose enable is low returns zero. Reads sample the
// array before the write of the same edge lands (read-before-write).
// Assumes synchronous active-low reset clears every entry.
module segmap_bank #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    parameter int PORTS   = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [$clog2(ENTRIES)-1:0]             wr_idx,
    input  logic [WIDTH-1:0]                       wr_data,
    input  logic [PORTS-1:0]                       rd_en,
    input  logic [PORTS-1:0][$clog2(ENTRIES)-1:0]  rd_idx,
    output logic [PORTS-1:0][WIDTH-1:0]            rd_q
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [WIDTH-1:0] mem [ENTRIES];

    // Clear on reset, otherwise store the write on the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        logic [IDX_W-1:0] sel;
        assign sel = rd_idx[p];
        // Register the selected entry, or zero when the port is idle.
        always_ff @(posedge clk) begin
            if (!rst_n)         rd_q[p] <= '0;
            else if (rd_en[p])  rd_q[p] <= mem[sel];
            else                rd_q[p] <= '0;
        end
    end
endmodule

// File: rtl/segmap_top.sv
// Module: segmap_top
// Segment map register file with a primary copy (data lookups and move-out)
// and a mirror copy (instruction lookups). Privileged moves write both copies
// together; user-level moves are refused with a one-cycle fault pulse.
// Assumes the effective-address top bits select the entry.
module segmap_top
    import segmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sup_mode,
    input  logic                 mv_wr_en,
    input  logic [SEG_IDX_W-1:0] mv_wr_idx,
    input  logic [SEG_WIDTH-1:0] mv_wr_data,
    input  logic                 mv_rd_en,
    input  logic [SEG_IDX_W-1:0] mv_rd_idx,
    output logic [SEG_WIDTH-1:0] mv_rd_data,
    output logic                 priv_fault,
    input  logic [EA_WIDTH-1:0]  d_ea,
    output logic [SEG_WIDTH-1:0] d_entry,
    input  logic [EA_WIDTH-1:0]  i_ea,
    output logic [SEG_WIDTH-1:0] i_entry
);
    localparam int PRI_PORTS = 2;
    localparam int MIR_PORTS = 1;

    logic     wr_ok, rd_ok;
    seg_idx_t d_idx, i_idx;

    logic [PRI_PORTS-1:0]                pri_en;
    logic [PRI_PORTS-1:0][SEG_IDX_W-1:0] pri_idx;
    logic [PRI_PORTS-1:0][SEG_WIDTH-1:0] pri_q;
    logic [MIR_PORTS-1:0]                mir_en;
    logic [MIR_PORTS-1:0][SEG_IDX_W-1:0] mir_idx;
    logic [MIR_PORTS-1:0][SEG_WIDTH-1:0] mir_q;

    segmap_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .sup_mode(sup_mode),
        .wr_req  (mv_wr_en),
        .rd_req  (mv_rd_en),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .fault_q (priv_fault)
    );

    // Pick the entry index from the top address bits and route read ports.
    always_comb begin
        d_idx      = d_ea[EA_WIDTH-1 -: SEG_IDX_W];
        i_idx      = i_ea[EA_WIDTH-1 -: SEG_IDX_W];
        pri_en     = {rd_ok, 1'b1};
        pri_idx[0] = d_idx;
        pri_idx[1] = mv_rd_idx;
        mir_en     = 1'b1;
        mir_idx[0] = i_idx;
    end

    segmap_bank #(.ENTRIES(SEG_ENTRIES), .WIDTH(SEG_WIDTH), .PORTS(PRI_PORTS)) u_primary (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .wr_idx (mv_wr_idx),
        .wr_data(mv_wr_data),
        .rd_en  (pri_en),
        .rd_idx (pri_idx),
        .rd_q   (pri_q)
    );

    segmap_bank #(.ENTRIES(SEG_ENTRIES), .WIDTH(SEG_WIDTH), .PORTS(MIR_PORTS)) u_mirror (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .wr_idx (mv_wr_idx),
        .wr_data(mv_wr_data),
        .rd_en  (mir_en),
        .rd_idx (mir_idx),
        .rd_q   (mir_q)
    );

    // Drive the registered results onto the ports.
    always_comb begin
        d_entry    = pri_q[0];
        mv_rd_data = pri_q[1];
        i_entry    = mir_q[0];
    end

    // Copies agree whenever both lookups hit the same entry (R3).
    assert_copies_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (d_ea[EA_WIDTH-1 -: SEG_IDX_W] == i_ea[EA_WIDTH-1 -: SEG_IDX_W]) |=> (d_entry == i_entry));

    // A user-level move faults in the next cycle (R6).
    assert_user_move_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_mode && (mv_wr_en || mv_rd_en)) |=> priv_fault);

    // Supervisor cycles never fault (R6).
    assert_sup_no_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sup_mode |=> !priv_fault);

    // A refused move-out reads as zero (R7).
    assert_refused_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_rd_en && !sup_mode) |=> (mv_rd_data == '0));

    // No move-out request gives zero (R9).
    assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_rd_en |=> (mv_rd_data == '0));
endmodule

// File: tb/segmap_top_test.sv
module segmap_top_test;
    import segmap_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sup_mode = 1'b1;
    logic                 mv_wr_en = 1'b0;
    logic [SEG_IDX_W-1:0] mv_wr_idx = '0;
    logic [SEG_WIDTH-1:0] mv_wr_data = '0;
    logic                 mv_rd_en = 1'b0;
    logic [SEG_IDX_W-1:0] mv_rd_idx = '0;
    logic [SEG_WIDTH-1:0] mv_rd_data;
    logic                 priv_fault;
    logic [EA_WIDTH-1:0]  d_ea = '0;
    logic [SEG_WIDTH-1:0] d_entry;
    logic [EA_WIDTH-1:0]  i_ea = '0;
    logic [SEG_WIDTH-1:0] i_entry;

    segmap_top uut (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic [SEG_WIDTH-1:0] d_exp;
        logic [SEG_WIDTH-1:0] i_exp;
        logic [SEG_WIDTH-1:0] rd_exp;
        logic                 f_exp;
        string                tag;
    } exp_t;

    exp_t                 sb[$];
    logic [SEG_WIDTH-1:0] model [SEG_ENTRIES];
    int                   tests = 0;
    int                   fails = 0;
    bit                   finished = 1'b0;

    // Monitor: compare design outputs with the oldest expected item.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            tests += 4;
            if (d_entry !== e.d_exp) begin
                fails++;
                $display("FAIL %s d_entry actual=%h expected=%h", e.tag, d_entry, e.d_exp);
            end
            if (i_entry !== e.i_exp) begin
                fails++;
                $display("FAIL %s i_entry actual=%h expected=%h", e.tag, i_entry, e.i_exp);
            end
            if (mv_rd_data !== e.rd_exp) begin
                fails++;
                $display("FAIL %s mv_rd_data actual=%h expected=%h", e.tag, mv_rd_data, e.rd_exp);
            end
            if (priv_fault !== e.f_exp) begin
                fails++;
                $display("FAIL %s priv_fault actual=%b expected=%b", e.tag, priv_fault, e.f_exp);
            end
        end
    end

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic rst, input logic sup,
                        input logic we, input logic [3:0] widx, input logic [31:0] wdata,
                        input logic re, input logic [3:0] ridx,
                        input logic [31:0] dea, input logic [31:0] iea, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = ~rst; sup_mode = sup;
        mv_wr_en = we; mv_wr_idx = widx; mv_wr_data = wdata;
        mv_rd_en = re; mv_rd_idx = ridx;
        d_ea = dea; i_ea = iea;
        e.tag = tag;
        if (rst) begin
            e.d_exp = '0; e.i_exp = '0; e.rd_exp = '0; e.f_exp = 1'b0;
            for (int k = 0; k < SEG_ENTRIES; k++) model[k] = '0;
        end else begin
            e.d_exp  = model[dea[31:28]];
            e.i_exp  = model[iea[31:28]];
            e.rd_exp = (re && sup) ? model[ridx] : '0;
            e.f_exp  = (we || re) && !sup;
            if (we && sup) model[widx] = wdata;
        end
        sb.push_back(e);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        step(1, 1, 0, 0, 0, 0, 0, 32'h0, 32'h0, "R8 reset");
        step(1, 1, 0, 0, 0, 0, 0, 32'hF000_0000, 32'h7000_0000, "R8 reset");

        // R2: fill all entries, look up each just after its write
        for (int k = 0; k < SEG_ENTRIES; k++) begin
            step(0, 1, 1, k[3:0], 32'hA500_0000 + 32'h0101 * k, 0, 0,
                 {k[3:0] - 4'd1, 28'h123_4567}, {k[3:0] - 4'd1, 28'hFED_CBA9}, "R2 R1 fill");
        end
        // R4 R1 R3: read back each entry with varying low address bits
        for (int k = 0; k < SEG_ENTRIES; k++) begin
            step(0, 1, 0, 0, 0, 1, k[3:0], {k[3:0], 28'h0000_000}, {k[3:0], 28'hFFF_FFFF}, "R4 R1 R3 readback");
        end
        // R2: lookup in cycle right after a write on both ports
        step(0, 1, 1, 4'd5, 32'hCAFE_0005, 0, 0, 32'h0, 32'h0, "R2 write");
        step(0, 1, 0, 0, 0, 0, 0, 32'h5000_0000, 32'h5ABC_0000, "R2 new value");
        // R5: same-cycle write and lookup/read of same entry returns old value
        step(0, 1, 1, 4'd9, 32'h1234_5678, 1, 4'd9, 32'h9000_0010, 32'h9FFF_0000, "R5 read-before-write");
        step(0, 1, 0, 0, 0, 1, 4'd9, 32'h9000_0000, 32'h9000_0000, "R5 R2 after");
        // R6 R7: user-level write and read refused
        step(0, 0, 1, 4'd3, 32'hDEAD_BEEF, 0, 0, 32'h3000_0000, 32'h3000_0000, "R6 R7 user write");
        step(0, 0, 0, 0, 0, 1, 4'd3, 32'h3000_0000, 32'h3000_0000, "R6 R7 user read");
        step(0, 0, 1, 4'd3, 32'hBAD0_0000, 1, 4'd3, 32'h3000_0000, 32'h3000_0000, "R6 R7 user both");
        step(0, 0, 0, 0, 0, 0, 0, 32'h3000_0000, 32'h3000_0000, "R6 idle user");
        step(0, 1, 0, 0, 0, 1, 4'd3, 32'h3000_0000, 32'h3000_0000, "R7 unchanged");
        // R9: idle supervisor cycle
        step(0, 1, 0, 0, 0, 0, 4'd3, 32'h3000_0000, 32'h0, "R9 idle");

        // Random mixed traffic: R1 R2 R3 R5 R6 R7 R9
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, b, w;
            logic [3:0]  wi, ri;
            logic        s, we, re, same;
            a = $urandom; b = $urandom; w = $urandom;
            wi = 4'($urandom); ri = 4'($urandom);
            s = ($urandom % 4) != 0; we = $urandom % 2; re = $urandom % 2;
            same = $urandom % 2;
            if (same) b[31:28] = a[31:28];
            step(0, s, we, wi, w, re, ri, a, b, "R1 R2 R3 R5 R6 R7 R9 random");
        end

        // R8: reset mid-run, then everything reads zero
        step(1, 1, 0, 0, 0, 0, 0, 32'h0, 32'h0, "R8 reset again");
        for (int k = 0; k < SEG_ENTRIES; k++) begin
            step(0, 1, 0, 0, 0, 1, k[3:0], {k[3:0], 28'h0}, {k[3:0], 28'h1}, "R8 cleared");
        end

        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "drain");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule